// File: doc/BRIEF.md
# PCM Transmit Serial Port with Frame Sync Classification

This block sends one 8-bit PCM code word per frame, most significant bit first, on a serial data line that is driven only while the word is on it. The line is paced by an external bit clock, and each frame is started by a transmit frame sync. The block measures how long each frame sync stays high and sorts it into one of two formats. A short sync lasts one bit period. A long sync lasts three or more. The format found decides when the output turns on and when it turns off.

The bit clock and frame sync are sampled by a fast system clock, and their edges are found there. This lets the whole port run in a single clock domain. A code word is written into a holding register with a one-cycle valid strobe. The word in that register is copied into the shift register when a frame starts. If no new word arrives, the last one is sent again. Rather than a real tri-state pad, the block drives the data line and a separate output-enable, and the pad sits outside the block.

Top module: `pcm_tx_port`

## Requirements
- R1: During and after reset, `sdata_oe` is 0, `sdata` is 0 and `long_mode` is 0 (short format).
- R2: Short format: when `fsync` is high at a falling `bclk` edge and no word is being sent, the next rising `bclk` edge sets `sdata_oe` and puts bit 7 of the word on `sdata`.
- R3: While enabled, each later rising `bclk` edge moves on to the next lower bit, until all 8 bits (7 down to 0) have been sent.
- R4: In a frame started under the short format, `sdata_oe` clears at the first falling `bclk` edge after the rising edge that sent bit 0.
- R5: At each falling edge of `fsync`, `long_mode` becomes 1 if `fsync` was high at three or more falling `bclk` edges of that pulse, and 0 otherwise. The new value governs the next frame.
- R6: Long format: the output turns on with bit 7 at the later of the `fsync` rising edge and a rising `bclk` edge. If `bclk` is already high when `fsync` rises, it turns on at once. If `bclk` is low, it waits for the next rising `bclk` edge.
- R7: In a frame started under the long format, `sdata_oe` clears at whichever comes later: the first falling `bclk` edge after bit 0 is sent, or `fsync` being low.
- R8: `code_valid` high stores `code_in`, and that stored word is loaded at the start of each frame. A changed `code_in` without `code_valid` has no effect, and the previous word is sent again.
- R9: While `pwr_en` is 0, `sdata_oe` is 0 from the next clock on, any frame in progress is dropped and new frame syncs start nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than `bclk` |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | 1 = port active, 0 = powered down |
| bclk | input | 1 | Bit clock, synchronous to `clk` |
| fsync | input | 1 | Transmit frame sync, synchronous to `clk` |
| code_in | input | WORD_W | Parallel PCM code word |
| code_valid | input | 1 | Strobe that stores `code_in` |
| sdata | output | 1 | Serial data, 0 while not enabled |
| sdata_oe | output | 1 | Output enable for the serial data pad |
| long_mode | output | 1 | Detected frame sync format, 1 = long |

## Verification
A `bclk` or `fsync` edge is first seen at the `clk` edge where the new level is sampled. The enable, the data bit and `long_mode` all change on that same `clk` edge, so every result is due one `clk` after the input changes. The bench divides each bit period into four quarters of two `clk` cycles. It changes inputs only at quarter boundaries and samples the outputs at the last falling `clk` edge of each quarter, one full cycle after the edge that caused the change. The expected enable pattern is tabulated per quarter for each frame. The expected data bit is indexed by counting rising `bclk` edges from the quarter where the enable first appears.

// File: rtl/pcm_tx_pkg.sv
`timescale 1ns/1ps
package pcm_tx_pkg;

    // Per-signal edge information derived from one oversampled input
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } sig_edge_t;

    // Transmit sequencer states
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SEND  = 2'd2,
        TX_LINGER = 2'd3
    } tx_state_e;

    // Control strobes from sequencer to datapath
    typedef struct packed {
        logic load;
        logic shift;
    } dp_ctrl_t;

    // Saturating increment
    function automatic logic [7:0] sat_inc8(input logic [7:0] v, input logic [7:0] lim);
        return (v < lim) ? v + 8'd1 : v;
    endfunction

endpackage

// File: rtl/pcm_edge_det.sv
`timescale 1ns/1ps
module pcm_edge_det
    import pcm_tx_pkg::*;
#(
    parameter int N = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          din,
    output sig_edge_t [N-1:0]     ev
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= din[i];
        end
        assign ev[i].level = din[i];
        assign ev[i].rise  = din[i] & ~prev_q[i];
        assign ev[i].fall  = ~din[i] & prev_q[i];
    end

endmodule

// File: rtl/pcm_sync_classifier.sv
`timescale 1ns/1ps
module pcm_sync_classifier
    import pcm_tx_pkg::*;
#(
    parameter int LONG_MIN = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  sig_edge_t bit_ev,
    input  sig_edge_t fs_ev,
    output logic      long_mode
);

    localparam logic [7:0] LIM = 8'(LONG_MIN);

    logic [7:0] hi_cnt_q;
    logic       long_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt_q <= 8'd0;
            long_q   <= 1'b0;
        end else begin
            if (fs_ev.rise) begin
                hi_cnt_q <= bit_ev.fall ? 8'd1 : 8'd0;
            end else if (fs_ev.level && bit_ev.fall) begin
                hi_cnt_q <= sat_inc8(hi_cnt_q, LIM);
            end
            if (fs_ev.fall) begin
                long_q <= (hi_cnt_q >= LIM);
            end
        end
    end

    assign long_mode = long_q;

endmodule

// File: rtl/pcm_tx_seq.sv
`timescale 1ns/1ps
module pcm_tx_seq
    import pcm_tx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_en,
    input  sig_edge_t bit_ev,
    input  sig_edge_t fs_ev,
    input  logic      long_mode,
    output dp_ctrl_t  ctrl,
    output logic      drive
);

    localparam int BL_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [BL_W-1:0] LAST = BL_W'(WORD_W - 1);

    tx_state_e       state_q, state_d;
    logic [BL_W-1:0] left_q, left_d;
    logic            flong_q, flong_d;

    always_comb begin
        state_d    = state_q;
        left_d     = left_q;
        flong_d    = flong_q;
        ctrl.load  = 1'b0;
        ctrl.shift = 1'b0;
        case (state_q)
            TX_IDLE: begin
                if (long_mode) begin
                    if (fs_ev.rise) begin
                        flong_d = 1'b1;
                        if (bit_ev.level) begin
                            ctrl.load = 1'b1;
                            left_d    = LAST;
                            state_d   = TX_SEND;
                        end else begin
                            state_d   = TX_ARMED;
                        end
                    end
                end else if (bit_ev.fall && fs_ev.level) begin
                    flong_d = 1'b0;
                    state_d = TX_ARMED;
                end
            end
            TX_ARMED: begin
                if (bit_ev.rise) begin
                    ctrl.load = 1'b1;
                    left_d    = LAST;
                    state_d   = TX_SEND;
                end
            end
            TX_SEND: begin
                if (bit_ev.rise && left_q != '0) begin
                    ctrl.shift = 1'b1;
                    left_d     = left_q - 1'b1;
                end else if (bit_ev.fall && left_q == '0) begin
                    state_d = (flong_q && fs_ev.level) ? TX_LINGER : TX_IDLE;
                end
            end
            TX_LINGER: begin
                if (!fs_ev.level) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
        if (!pwr_en) begin
            ctrl.load  = 1'b0;
            ctrl.shift = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_en) begin
            state_q <= TX_IDLE;
            left_q  <= '0;
            flong_q <= 1'b0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            flong_q <= flong_d;
        end
    end

    assign drive = (state_q == TX_SEND) || (state_q == TX_LINGER);

endmodule

// File: rtl/pcm_tx_datapath.sv
`timescale 1ns/1ps
module pcm_tx_datapath
    import pcm_tx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] code_in,
    input  logic              code_valid,
    input  dp_ctrl_t          ctrl,
    output logic              msb
);

    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            sh_q   <= '0;
        end else begin
            if (code_valid) hold_q <= code_in;
            if (ctrl.load)       sh_q <= hold_q;
            else if (ctrl.shift) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[WORD_W-1];

endmodule

// File: rtl/pcm_tx_port.sv
`timescale 1ns/1ps
module pcm_tx_port
    import pcm_tx_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int LONG_MIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_en,
    input  logic              bclk,
    input  logic              fsync,
    input  logic [WORD_W-1:0] code_in,
    input  logic              code_valid,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              long_mode
);

    localparam int SIG_N = 2;

    sig_edge_t [SIG_N-1:0] ev;
    dp_ctrl_t              ctrl;
    logic                  msb;
    logic                  drive;
    logic                  mode;

    pcm_edge_det #(.N(SIG_N)) u_edges (
        .clk (clk),
        .rst (rst),
        .din ({fsync, bclk}),
        .ev  (ev)
    );

    pcm_sync_classifier #(.LONG_MIN(LONG_MIN)) u_class (
        .clk       (clk),
        .rst       (rst),
        .bit_ev    (ev[0]),
        .fs_ev     (ev[1]),
        .long_mode (mode)
    );

    pcm_tx_seq #(.WORD_W(WORD_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pwr_en    (pwr_en),
        .bit_ev    (ev[0]),
        .fs_ev     (ev[1]),
        .long_mode (mode),
        .ctrl      (ctrl),
        .drive     (drive)
    );

    pcm_tx_datapath #(.WORD_W(WORD_W)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .code_in    (code_in),
        .code_valid (code_valid),
        .ctrl       (ctrl),
        .msb        (msb)
    );

    assign sdata_oe  = drive;
    assign sdata     = drive & msb;
    assign long_mode = mode;

endmodule

// File: rtl/pcm_tx_port_chk.sv
`timescale 1ns/1ps
module pcm_tx_port_chk (
    input logic clk,
    input logic rst,
    input logic pwr_en,
    input logic bclk,
    input logic fsync,
    input logic sdata_oe,
    input logic long_mode
);

    assert_power_off_R9: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> !sdata_oe);

    assert_short_start_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(sdata_oe) && !$past(long_mode)) |-> ($past(bclk) && !$past(bclk, 2)));

    assert_long_start_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(sdata_oe) && $past(long_mode)) |-> $past(bclk));

    assert_short_stop_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(sdata_oe) && $past(pwr_en) && !$past(long_mode)) |-> (!$past(bclk) && $past(bclk, 2)));

    assert_long_stop_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(sdata_oe) && $past(pwr_en) && $past(long_mode)) |-> !$past(fsync));

    assert_mode_on_sync_end_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(long_mode) |-> ($past(fsync, 2) && !$past(fsync)));

endmodule

bind pcm_tx_port pcm_tx_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_en    (pwr_en),
    .bclk      (bclk),
    .fsync     (fsync),
    .sdata_oe  (sdata_oe),
    .long_mode (long_mode)
);

// File: tb/pcm_tx_port_test.sv
`timescale 1ns/1ps
module pcm_tx_port_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_en = 1'b1;
    logic       bclk = 1'b0;
    logic       fsync = 1'b0;
    logic [7:0] code_in = 8'h00;
    logic       code_valid = 1'b0;
    logic       sdata, sdata_oe, long_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcm_tx_port uut (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .bclk(bclk), .fsync(fsync),
        .code_in(code_in), .code_valid(code_valid),
        .sdata(sdata), .sdata_oe(sdata_oe), .long_mode(long_mode)
    );

    // {code[105:98], load[97], fs per quarter[96:49], oe per quarter[48:1], mode after[0]}
    localparam int NV = 8;
    localparam logic [105:0] VEC [NV] = '{
        {8'hA5, 1'b1, 48'h0000_0000_000F, 48'h0003_FFFF_FFF0, 1'b0},
        {8'h3C, 1'b1, 48'h0000_0000_FFFF, 48'h0003_FFFF_FFF0, 1'b1},
        {8'h96, 1'b1, 48'h0000_0001_FFF8, 48'h0003_FFFF_FFF0, 1'b1},
        {8'h96, 1'b0, 48'h007F_FFFF_FFFE, 48'h007F_FFFF_FFFE, 1'b1},
        {8'hC3, 1'b1, 48'h0000_0000_1FFF, 48'h0000_3FFF_FFFF, 1'b1},
        {8'h0F, 1'b1, 48'h0000_0000_000F, 48'h0000_3FFF_FFFF, 1'b0},
        {8'h81, 1'b1, 48'h0000_0000_000F, 48'h0003_FFFF_FFF0, 1'b0},
        {8'h7E, 1'b1, 48'h0000_0000_0078, 48'h003F_FFFF_FF00, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string oe_tag(input int i);
        case (i)
            1:       return "R5 enable";
            2, 3, 4: return "R6/R7 enable";
            5:       return "R5/R6 enable";
            default: return "R2/R4 enable";
        endcase
    endfunction

    task automatic run_frame(input logic [7:0] code, input logic ld,
                             input logic [47:0] fsv, input logic [47:0] oev,
                             input logic md, input int drop_q,
                             input string otag, input string dtag);
        int  idx;
        bit  prev;
        idx  = -1;
        prev = 1'b0;
        code_in = ld ? code : ~code;
        code_valid = ld;
        @(negedge clk);
        code_valid = 1'b0;
        for (int q = 0; q < 48; q++) begin
            if (q == drop_q) pwr_en = 1'b0;
            bclk  = ((q % 4) < 2);
            fsync = fsv[q];
            @(negedge clk);
            @(negedge clk);
            check(sdata_oe === oev[q], otag, int'(sdata_oe), int'(oev[q]));
            if (oev[q] && !prev) idx = 7;
            else if (oev[q] && prev && (q % 4) == 0) idx--;
            if (oev[q] && idx >= 0)
                check(sdata === code[idx], dtag, int'(sdata), int'(code[idx]));
            prev = oev[q];
        end
        check(long_mode === md, "R5 mode", int'(long_mode), int'(md));
        pwr_en = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        check(sdata_oe === 1'b0, "R1 oe", int'(sdata_oe), 0);
        check(sdata === 1'b0, "R1 sdata", int'(sdata), 0);
        check(long_mode === 1'b0, "R1 mode", int'(long_mode), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sdata_oe === 1'b0, "R1 oe after release", int'(sdata_oe), 0);
        check(long_mode === 1'b0, "R1 mode after release", int'(long_mode), 0);

        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i][105:98], VEC[i][97], VEC[i][96:49], VEC[i][48:1], VEC[i][0],
                      48, oe_tag(i), (i == 3) ? "R3/R8 data" : "R3 data");
        end

        // R9: powered down, short sync ignored
        pwr_en = 1'b0;
        run_frame(8'h55, 1'b1, 48'h0000_0000_000F, 48'h0, 1'b0, 0, "R9 off", "R9 data");
        // R9: power removed mid-word
        run_frame(8'hB4, 1'b1, 48'h0000_0000_000F, 48'h0000_0000_0FF0, 1'b0, 12,
                  "R9 drop", "R3 data");
        // R2/R4 again after power returns
        run_frame(8'h6D, 1'b1, 48'h0000_0000_000F, 48'h0003_FFFF_FFF0, 1'b0, 48,
                  "R2/R4 enable", "R3 data");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule